// File: doc/BRIEF.md
# External Bus Burst and Port-Sizing Sequencer

This block is a bus master sequencer. It sits between an internal requester and an external bus. It takes one transfer request, given as an address, a size code, a direction and write data. It turns that request into bus beats sized for the chip-select region the address falls in. A region holds a port that is 8, 16 or 32 bits wide. A transfer wider than its port is split into port-sized beats, and the address steps up by the port width on each beat.

Each region has two burst enables, one for reads and one for writes. When the enable for the request's direction is set, the beats run as a single burst: one start strobe, two clocks for the first beat and one clock for each later beat. When that enable is clear, every beat is a separate two-clock cycle with its own start strobe. The target stretches any beat by holding its acknowledge high.

The size code stays on the bus for the whole transfer. The in-progress strobe stays low through every beat, and it also stays low through the one turnaround cycle when the next request is already waiting. Read bytes are gathered big-endian into a right-justified internal word. The requester sees a one-cycle acknowledge in the clock where the last beat completes.

Top module: `busBurstSeq`

## Requirements
- R1: Size codes 00, 01, 10 and 11 mean 4, 1, 2 and 16 bytes. The port code of the region uses the same values: 01 is an 8-bit port, 10 is 16-bit and 00 is 32-bit. A transfer of N bytes to a P-byte port takes N/P beats when N > P, and one beat otherwise.
- R2: `busSiz` carries the request's size code on every beat of the transfer and does not change between beats.
- R3: Beat k of a transfer puts address `reqAddr + k*P` on `busAddr`.
- R4: With the region's burst bit set for the request's direction and more than one beat, the transfer has exactly one `tsN` pulse. Without wait states it takes 1 + beats clocks from `tsN` to the last acknowledge.
- R5: With that burst bit clear, each beat has its own one-clock `tsN` pulse, and each beat takes 2 clocks without wait states.
- R6: A beat completes only on a clock where `taN` is sampled low. Each clock of the data phase with `taN` high adds one clock to the transfer.
- R7: `tsN` is low for exactly one clock per bus cycle. `tipN` is low on every clock where a chip select is asserted.
- R8: Suppose `reqValid` is high in the clock after the acknowledge. Then `tipN` stays low through that clock, and `tsN` of the next transfer follows in the clock after it. If `reqValid` is low in that clock, `tipN` is high.
- R9: Byte lane 0 is `busDout/busDin[31:24]`, enabled by `bsN[3]`, and lane 3 is `[7:0]`, enabled by `bsN[0]`. The first lane used is `addr mod P` when N < P, and 0 otherwise. The beat uses min(N,P) lanes, driven low on `bsN`. Transfer byte i of a write is taken from `reqWdata[(N-1-i)*8 +: 8]`. `oeN` is low during the data phase of read beats only.
- R10: On a read, the byte from address `reqAddr+i` appears at `rspRdata[(N-1-i)*8 +: 8]` in the clock where `reqAck` is high.
- R11: `reqAck` is high only in the clock where the last beat's `taN` is low. Chip select `csN[r]` is low during the transfer, with r = `reqAddr[29:28]`, and the other selects are high.
- R12: After reset, `tsN`, `tipN`, `oeN` and all of `csN` are high, and `reqAck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; held until reqAck |
| reqAddr | input | 32 | Transfer start address |
| reqSize | input | 2 | Transfer size code |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 128 | Write data, right-justified, big-endian |
| reqAck | output | 1 | Last beat completed |
| rspRdata | output | 128 | Read data, valid with reqAck |
| cfgPortSz | input | 8 | Port code per region, 2 bits each, region 0 lowest |
| cfgBurstRd | input | 4 | Read burst enable per region |
| cfgBurstWr | input | 4 | Write burst enable per region |
| busAddr | output | 32 | Beat address |
| busSiz | output | 2 | Whole-transfer size code |
| busRnW | output | 1 | 1 = read |
| tsN | output | 1 | Cycle start strobe, active low |
| tipN | output | 1 | Transfer in progress, active low |
| csN | output | 4 | Chip selects, active low |
| bsN | output | 4 | Byte lane enables, active low |
| oeN | output | 1 | Output enable for reads, active low |
| busDout | output | 32 | Write data lanes |
| busDin | input | 32 | Read data lanes |
| taN | input | 1 | Beat acknowledge from target, active low |

## Verification
The bench sends 32-bit and line transfers to an 8-bit port in both directions. One of them moves a full line as sixteen separate cycles. A wrong byte offset there would shuffle bytes in the assembled word or on the write lanes, and a beat count that is off by one would show as a missing or extra acknowledged beat. Regions are mixed so that read bursting is on where write bursting is off, and the reverse. A design that picked the wrong direction bit would show an extra or a missing `tsN` pulse and a wrong cycle count. Sub-port accesses at odd lanes catch wrong lane steering, and wait states of one and two clocks catch a design that completes a beat without `taN`. A chained pair of transfers must keep `tipN` low through the gap, and an unchained one must release it.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture a new request
    logic step;   // a beat completed (target acknowledged)
    logic last;   // the completed beat was the final one
  } seqStrobe_t;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_LINE = 2'b11
  } sizeCode_t;

  function automatic int xferBytes(input logic [1:0] code, input int lineBytes);
    case (code)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_LINE: return lineBytes;
      default: return 4;
    endcase
  endfunction

  function automatic int portBytes(input logic [1:0] code, input int busBytes);
    case (code)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return busBytes;
    endcase
  endfunction

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
#(
  parameter int NCS    = 4,
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              taN,
  input  logic              burstIn,
  input  logic [BEAT_W-1:0] beatsIn,
  input  logic [NCS-1:0]    csSelIn,
  output seqStrobe_t        strobe,
  output logic              tsN,
  output logic              tipN,
  output logic              oeN,
  output logic              reqAck,
  output logic [NCS-1:0]    csN
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} seqState_t;

  seqState_t         stQ, stD;
  logic [BEAT_W-1:0] beatQ, beatsQ;
  logic              burstQ, readQ, chainQ;
  logic [NCS-1:0]    csQ;
  logic              taHit, lastBeat;

  assign taHit    = (stQ == S_DATA) && !taN;
  assign lastBeat = (beatQ == beatsQ - BEAT_W'(1));

  always_comb begin
    strobe.load = (stQ == S_IDLE) && reqValid;
    strobe.step = taHit;
    strobe.last = taHit && lastBeat;
  end

  always_comb begin
    stD = stQ;
    case (stQ)
      S_IDLE: if (reqValid) stD = S_ADDR;
      S_ADDR: stD = S_DATA;
      S_DATA: if (taHit) begin
        if (lastBeat)    stD = S_IDLE;
        else if (!burstQ) stD = S_ADDR;
      end
      default: stD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ    <= S_IDLE;
      beatQ  <= '0;
      beatsQ <= BEAT_W'(1);
      burstQ <= 1'b0;
      readQ  <= 1'b0;
      chainQ <= 1'b0;
      csQ    <= '0;
    end else begin
      stQ    <= stD;
      chainQ <= strobe.last;
      if (strobe.load) begin
        beatQ  <= '0;
        beatsQ <= beatsIn;
        burstQ <= burstIn;
        readQ  <= !reqWrite;
        csQ    <= csSelIn;
      end else if (strobe.step) begin
        beatQ <= beatQ + BEAT_W'(1);
      end
    end
  end

  assign tsN    = !(stQ == S_ADDR);
  assign tipN   = !((stQ != S_IDLE) || (chainQ && reqValid));
  assign csN    = (stQ != S_IDLE) ? ~csQ : '1;
  assign oeN    = !((stQ == S_DATA) && readQ);
  assign reqAck = strobe.last;

  a_r7_ts_single: assert property (@(posedge clk) disable iff (!rstN)
    !tsN |=> tsN);
  a_r11_ack_needs_ta: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> !taN);
  a_r11_cs_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  a_r4_burst_no_ts: assert property (@(posedge clk) disable iff (!rstN)
    (taHit && !lastBeat && burstQ) |=> (tsN && !tipN));
  a_r5_single_ts: assert property (@(posedge clk) disable iff (!rstN)
    (taHit && !lastBeat && !burstQ) |=> !tsN);

endmodule

// File: rtl/busSeqDpath.sv
module busSeqDpath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32,
  parameter int LINE_W = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqSize,
  input  logic                 reqWrite,
  input  logic [LINE_W-1:0]    reqWdata,
  input  logic [1:0]           portIn,
  input  logic [BUS_W-1:0]     busDin,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [1:0]           busSiz,
  output logic                 busRnW,
  output logic [BUS_W/8-1:0]   bsN,
  output logic [BUS_W-1:0]     busDout,
  output logic [LINE_W-1:0]    rspRdata
);

  localparam int LANES   = BUS_W / 8;
  localparam int LANE_AW = $clog2(LANES);
  localparam int LINE_B  = LINE_W / 8;
  localparam int OFF_W   = $clog2(LINE_B) + 1;

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizQ, portQ;
  logic              writeQ;
  logic [LINE_W-1:0] wdataQ, rdataQ, rdataD;
  logic [OFF_W-1:0]  offQ;
  int                nBytes, pBytes, laneStart, beatBytes, pos;

  // Lane steering: which lanes this beat uses, and which transfer byte sits on each
  always_comb begin
    nBytes    = xferBytes(sizQ, LINE_B);
    pBytes    = portBytes(portQ, LANES);
    laneStart = (nBytes < pBytes) ? (int'(addrQ[LANE_AW-1:0]) % pBytes) : 0;
    beatBytes = (nBytes < pBytes) ? nBytes : pBytes;
    bsN       = '1;
    busDout   = '0;
    rdataD    = rdataQ;
    pos       = 0;
    for (int ln = 0; ln < LANES; ln++) begin
      if (ln >= laneStart && ln < laneStart + beatBytes) begin
        pos = nBytes - 1 - (int'(offQ) + ln - laneStart);
        bsN[LANES-1-ln] = 1'b0;
        busDout[BUS_W-1-8*ln -: 8] = wdataQ[pos*8 +: 8];
        if (!writeQ) rdataD[pos*8 +: 8] = busDin[BUS_W-1-8*ln -: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizQ   <= '0;
      portQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      rdataQ <= '0;
      offQ   <= '0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr;
      sizQ   <= reqSize;
      portQ  <= portIn;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
      rdataQ <= '0;
      offQ   <= '0;
    end else if (strobe.step) begin
      addrQ  <= addrQ + ADDR_W'(pBytes);
      offQ   <= offQ + OFF_W'(pBytes);
      rdataQ <= rdataD;
    end
  end

  assign busAddr  = addrQ;
  assign busSiz   = sizQ;
  assign busRnW   = !writeQ;
  assign rspRdata = rdataD;

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.last) |=> (busAddr == $past(busAddr) + ADDR_W'($past(pBytes))));

endmodule

// File: rtl/busBurstSeq.sv
module busBurstSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32,
  parameter int LINE_W = 128,
  parameter int NCS    = 4,
  parameter int CS_LSB = 28
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqSize,
  input  logic                 reqWrite,
  input  logic [LINE_W-1:0]    reqWdata,
  output logic                 reqAck,
  output logic [LINE_W-1:0]    rspRdata,
  input  logic [2*NCS-1:0]     cfgPortSz,
  input  logic [NCS-1:0]       cfgBurstRd,
  input  logic [NCS-1:0]       cfgBurstWr,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [1:0]           busSiz,
  output logic                 busRnW,
  output logic                 tsN,
  output logic                 tipN,
  output logic [NCS-1:0]       csN,
  output logic [BUS_W/8-1:0]   bsN,
  output logic                 oeN,
  output logic [BUS_W-1:0]     busDout,
  input  logic [BUS_W-1:0]     busDin,
  input  logic                 taN
);

  localparam int LANES  = BUS_W / 8;
  localparam int LINE_B = LINE_W / 8;
  localparam int SEL_W  = $clog2(NCS);
  localparam int BEAT_W = $clog2(LINE_B) + 1;

  logic [SEL_W-1:0]  regSel;
  logic [1:0]        portCode;
  logic [BEAT_W-1:0] beatsReq;
  logic [NCS-1:0]    csSel;
  logic              burstReq;
  int                reqN, reqP;
  seqStrobe_t        strobe;

  // Region decode of the pending request
  always_comb begin
    regSel   = reqAddr[CS_LSB +: SEL_W];
    portCode = cfgPortSz[2*int'(regSel) +: 2];
    reqN     = xferBytes(reqSize, LINE_B);
    reqP     = portBytes(portCode, LANES);
    beatsReq = (reqN > reqP) ? BEAT_W'(reqN / reqP) : BEAT_W'(1);
    burstReq = (reqWrite ? cfgBurstWr[regSel] : cfgBurstRd[regSel]) && (reqN > reqP);
    csSel    = NCS'(1) << regSel;
  end

  busSeqCtrl #(.NCS(NCS), .BEAT_W(BEAT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .taN(taN),
    .burstIn(burstReq), .beatsIn(beatsReq), .csSelIn(csSel), .strobe(strobe),
    .tsN(tsN), .tipN(tipN), .oeN(oeN), .reqAck(reqAck), .csN(csN)
  );

  busSeqDpath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .LINE_W(LINE_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .portIn(portCode), .busDin(busDin),
    .busAddr(busAddr), .busSiz(busSiz), .busRnW(busRnW), .bsN(bsN),
    .busDout(busDout), .rspRdata(rspRdata)
  );

  a_r2_siz_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tipN && tsN && $past(!tipN)) |-> $stable(busSiz));

endmodule

// File: tb/test_busBurstSeq.sv
`timescale 1ns/100ps
module test_busBurstSeq;

  localparam logic [7:0] CFG_PORT = 8'b00_00_10_01; // r3 32b, r2 32b, r1 16b, r0 8b
  localparam logic [3:0] CFG_BRD  = 4'b0101;        // read burst in r0, r2
  localparam logic [3:0] CFG_BWR  = 4'b0110;        // write burst in r1, r2

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rstN, reqValid, reqWrite, reqAck;
  logic [31:0]  reqAddr, busAddr, busDout, busDin;
  logic [1:0]   reqSize, busSiz;
  logic [127:0] reqWdata, rspRdata;
  logic         busRnW, tsN, tipN, oeN, taN;
  logic [3:0]   csN, bsN;

  busBurstSeq i_busBurstSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .reqAck(reqAck), .rspRdata(rspRdata),
    .cfgPortSz(CFG_PORT), .cfgBurstRd(CFG_BRD), .cfgBurstWr(CFG_BWR),
    .busAddr(busAddr), .busSiz(busSiz), .busRnW(busRnW), .tsN(tsN), .tipN(tipN),
    .csN(csN), .bsN(bsN), .oeN(oeN), .busDout(busDout), .busDin(busDin), .taN(taN)
  );

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  siz;
    logic        rnw;
    logic [3:0]  bsN;
    logic [31:0] dout;
  } beatExp_t;

  typedef struct {
    logic [127:0] rdata;
    logic         isRead;
    int           tsExp;
    int           cycExp;
  } xferExp_t;

  beatExp_t beatQ[$];
  xferExp_t xferQ[$];
  int checks = 0, failures = 0;
  int waitStates = 0, waitCnt = 0, tsCnt = 0, cycCnt = 0, ackCount = 0, wdog = 0;

  function automatic int bytesOf(input logic [1:0] c);
    case (c) 2'b01: return 1; 2'b10: return 2; 2'b11: return 16; default: return 4; endcase
  endfunction

  function automatic int regionPort(input logic [31:0] a);
    case (a[29:28]) 2'd0: return 1; 2'd1: return 2; default: return 4; endcase
  endfunction

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Driver: push expected beats and transfer result, then present the request
  task automatic startXfer(input logic [31:0] addr, input logic [1:0] size, input bit write,
                           input logic [127:0] wdata, input int waits);
    int n, p, beats, bb, ls;
    bit burst;
    xferExp_t x;
    n = bytesOf(size);
    p = regionPort(addr);
    beats = (n > p) ? n / p : 1;
    bb = (n < p) ? n : p;
    ls = (n < p) ? (int'(addr[1:0]) % p) : 0;
    burst = (write ? CFG_BWR[addr[29:28]] : CFG_BRD[addr[29:28]]) && (n > p);
    for (int k = 0; k < beats; k++) begin
      beatExp_t e;
      e.addr = addr + 32'(k * p);
      e.siz  = size;
      e.rnw  = !write;
      e.bsN  = 4'hF;
      e.dout = '0;
      for (int ln = ls; ln < ls + bb; ln++) begin
        int i;
        i = k * p + ln - ls;
        e.bsN[3-ln] = 1'b0;
        e.dout[31-8*ln -: 8] = wdata[(n-1-i)*8 +: 8];
      end
      beatQ.push_back(e);
    end
    x.rdata  = '0;
    x.isRead = !write;
    if (!write) for (int i = 0; i < n; i++) x.rdata[(n-1-i)*8 +: 8] = memByte(addr + 32'(i));
    x.tsExp  = burst ? 1 : beats;
    x.cycExp = burst ? 1 + beats * (1 + waits) : beats * (2 + waits);
    xferQ.push_back(x);
    waitStates = waits;
    reqAddr  = addr;
    reqSize  = size;
    reqWrite = write;
    reqWdata = wdata;
    reqValid = 1'b1;
  endtask

  task automatic waitAck(input bit keep);
    int start;
    start = ackCount;
    while (ackCount == start) begin
      @(negedge clk);
      #1.5;
    end
    if (!keep) reqValid = 1'b0;
  endtask

  task automatic checkGap(input bit chained);
    @(negedge clk);
    #1.5;
    if (chained) begin
      check(tipN == 1'b0, "R8", "tipN in chained gap", 128'(tipN), 128'(0));
      @(negedge clk);
      #1.5;
      check(tsN == 1'b0, "R8", "tsN after chained gap", 128'(tsN), 128'(0));
    end else begin
      check(tipN == 1'b1, "R8", "tipN idle unchained", 128'(tipN), 128'(1));
    end
  endtask

  // Target model and scoreboard monitor
  always @(negedge clk) begin
    if (!rstN) begin
      taN = 1'b1;
      busDin = '0;
      waitCnt = 0;
    end else begin
      int p;
      logic [31:0] base;
      if (csN != 4'hF && tsN) begin
        if (waitCnt >= waitStates) begin taN = 1'b0; waitCnt = 0; end
        else begin taN = 1'b1; waitCnt++; end
      end else begin
        taN = 1'b1;
        waitCnt = 0;
      end
      p = regionPort(busAddr);
      base = busAddr & ~32'(p - 1);
      for (int ln = 0; ln < 4; ln++)
        busDin[31-8*ln -: 8] = (ln < p) ? memByte(base + 32'(ln)) : 8'hEE;
      #1;
      if (csN != 4'hF) begin
        cycCnt++;
        check(tipN == 1'b0, "R7", "tipN during access", 128'(tipN), 128'(0));
      end
      if (!tsN) tsCnt++;
      if (!taN && csN != 4'hF) begin
        if (beatQ.size() == 0) begin
          check(1'b0, "R1", "unexpected extra beat", 128'(busAddr), 128'(0));
        end else begin
          beatExp_t e;
          logic [31:0] mask;
          e = beatQ.pop_front();
          mask = {{8{!e.bsN[3]}}, {8{!e.bsN[2]}}, {8{!e.bsN[1]}}, {8{!e.bsN[0]}}};
          check(busAddr == e.addr, "R3", "beat address", 128'(busAddr), 128'(e.addr));
          check(busSiz == e.siz, "R2", "size code on beat", 128'(busSiz), 128'(e.siz));
          check(bsN == e.bsN, "R9", "byte lanes", 128'(bsN), 128'(e.bsN));
          check(oeN == !e.rnw && busRnW == e.rnw, "R9", "oeN/direction",
                128'({oeN, busRnW}), 128'({!e.rnw, e.rnw}));
          check(csN == ~(4'b0001 << e.addr[29:28]), "R11", "chip select",
                128'(csN), 128'(~(4'b0001 << e.addr[29:28])));
          if (!e.rnw)
            check((busDout & mask) == e.dout, "R9", "write lanes", 128'(busDout & mask), 128'(e.dout));
        end
      end
      if (reqAck) begin
        if (xferQ.size() == 0) begin
          check(1'b0, "R11", "unexpected ack", 128'(1), 128'(0));
        end else begin
          xferExp_t x;
          x = xferQ.pop_front();
          check(!taN, "R11", "ack without taN", 128'(taN), 128'(0));
          check(beatQ.size() == 0, "R1", "beats left at ack", 128'(beatQ.size()), 128'(0));
          if (x.isRead) check(rspRdata == x.rdata, "R10", "read data", rspRdata, x.rdata);
          check(tsCnt == x.tsExp, "R4 R5", "tsN pulses", 128'(tsCnt), 128'(x.tsExp));
          check(cycCnt == x.cycExp, "R4 R5 R6", "transfer clocks", 128'(cycCnt), 128'(x.cycExp));
        end
        tsCnt = 0;
        cycCnt = 0;
        ackCount++;
      end
    end
  end

  always @(posedge clk) begin
    wdog++;
    if (wdog > 50000) begin
      failures++;
      $display("FAIL watchdog expired act=%0d exp=0", wdog);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    reqValid = 1'b0;
    reqAddr = '0;
    reqSize = '0;
    reqWrite = 1'b0;
    reqWdata = '0;
    repeat (3) @(negedge clk);
    #1.5;
    // R12 reset state
    check(tsN && tipN && oeN && csN == 4'hF && !reqAck, "R12", "reset outputs",
          128'({tsN, tipN, oeN, csN, reqAck}), 128'({1'b1, 1'b1, 1'b1, 4'hF, 1'b0}));
    rstN = 1'b1;
    @(negedge clk);
    #1.5;

    // R9 byte read on a 32-bit port at lane 1
    startXfer(32'h2000_0301, 2'b01, 1'b0, '0, 0);
    waitAck(0); checkGap(0);
    // R4 32-bit read bursting to an 8-bit port
    startXfer(32'h0000_0100, 2'b00, 1'b0, '0, 0);
    waitAck(0); checkGap(0);
    // R5 32-bit write to an 8-bit port, write burst off
    startXfer(32'h0000_0104, 2'b00, 1'b1, 128'hC1C2C3C4, 0);
    waitAck(0); checkGap(0);
    // R4 line read bursting on a 32-bit port
    startXfer(32'h2000_0300, 2'b11, 1'b0, '0, 0);
    waitAck(0); checkGap(0);
    // R5 line read to a burst-inhibited region
    startXfer(32'h3000_0400, 2'b11, 1'b0, '0, 0);
    waitAck(0); checkGap(0);
    // R4 32-bit write bursting on a 16-bit port
    startXfer(32'h1000_0200, 2'b00, 1'b1, 128'h8899AABB, 0);
    waitAck(0); checkGap(0);
    // R1 16-bit read on a 16-bit port is one beat
    startXfer(32'h1000_0202, 2'b10, 1'b0, '0, 0);
    waitAck(0); checkGap(0);
    // R6 wait states in a burst
    startXfer(32'h0000_0108, 2'b00, 1'b0, '0, 2);
    waitAck(0); checkGap(0);
    // R6 wait states on a line write burst
    startXfer(32'h2000_0310, 2'b11, 1'b1, 128'h00112233_44556677_8899AABB_CCDDEEFF, 1);
    waitAck(0); checkGap(0);
    // R8 chained: byte write at lane 3, then 16-bit read burst on 8-bit port
    startXfer(32'h2000_0303, 2'b01, 1'b1, 128'h5E, 0);
    waitAck(1);
    startXfer(32'h0000_0106, 2'b10, 1'b0, '0, 0);
    checkGap(1);
    waitAck(0); checkGap(0);
    // R9 16-bit write on lanes 2 and 3
    startXfer(32'h2000_0302, 2'b10, 1'b1, 128'h7A3C, 0);
    waitAck(0); checkGap(0);
    // R1 line write as sixteen single cycles on an 8-bit port
    startXfer(32'h0000_0120, 2'b11, 1'b1, 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F, 0);
    waitAck(0); checkGap(0);

    check(xferQ.size() == 0 && beatQ.size() == 0, "R11", "leftover expectations",
          128'(xferQ.size() + beatQ.size()), 128'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule